// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the seconds, minutes and hours of a real-time clock as three packed-BCD bytes. A one-pulse-per-second tick moves them forward. Seconds carry into minutes, and minutes carry into hours. A serial front end loads the bytes through a write port, which takes a strobe, an address and a byte. It reads them back through a combinational read port.

Two control bits live inside the registers themselves:

- **Halt flag.** The top bit of the seconds byte freezes the whole counter.
- **Mode bit.** The top bit of the hours byte selects 12-hour or 24-hour counting. In 24-hour mode, bit 5 of the hours byte is the high bit of the tens-of-hours digit. In 12-hour mode, the same bit is the afternoon flag.

Reset leaves the counter halted at zero. Time does not move until software writes the seconds byte with the halt flag cleared.

Top module: `tod_bcd_counter`

## Requirements
- R1: After reset, the seconds byte reads 0x80 (halted, 00), the minutes byte reads 0x00 and the hours byte reads 0x00.
- R2: The read port is combinational. `rd_addr_i` 0 returns seconds, 1 returns minutes, 2 returns hours, and 3 returns 0x00.
- R3: A strobe on `wr_en_i` loads `wr_data_i` into the addressed byte, and the new value is visible from the next cycle. Minutes bit 7 and hours bit 6 are always stored as 0. A write to address 3 changes no byte.
- R4: While seconds bit 7 is 1, ticks change no byte.
- R5: Seconds hold units in bits 3:0 and tens in bits 6:4. An accepted tick adds one, and 59 wraps to 00 with a carry into minutes on the same edge.
- R6: Minutes use the same digit layout, wrap from 59 to 00 and carry into hours on the same edge.
- R7: With hours bit 7 at 0 (24-hour mode), bits 5:4 are the tens digit and bits 3:0 the units digit. A carry advances 23 to 00.
- R8: With hours bit 7 at 1 (12-hour mode), bit 4 is the tens digit, bits 3:0 the units digit, and bit 5 the afternoon flag (0 = AM, 1 = PM). A carry steps 12 to 01 and 11 to 12, and bit 5 inverts only on the step from 11 to 12.
- R9: When `wr_en_i` and `tick_i` are high in the same cycle, the write happens and the tick is dropped entirely, with no advance and no carry.
- R10: Increments never change seconds bit 7 or hours bit 7. In 12-hour mode, bit 5 changes only as R8 states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 seconds, 1 minutes, 2 hours |
| wr_data_i | input | 8 | Byte to write |
| rd_addr_i | input | 2 | Read address, same encoding |
| rd_data_o | output | 8 | Addressed byte, combinational |

## Verification
The counter is run from several loaded start points:

- **Seconds and minutes carries.** Separate runs start just before each carry.
- **24-hour midnight wrap.** A run starts just before the wrap.
- **12-hour steps.** Runs cover the step from 11 to 12 in AM and in PM, and the step from 12 to 01. Together they show whether the afternoon flag inverts only where it should.
- **Halted ticks and ticks that coincide with writes.** These separate the halt path from the write-priority path.
- **Writes to address 3 and writes to the reserved bits.** These show that nothing else is disturbed.
- **Long irregular tick pattern.** A run of about an hour of simulated time with this pattern confirms that long carry chains agree with a decimal model.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int ADDR_W = 2;
    localparam int BYTE_W = 8;
    localparam int DIG_W  = 7;

    localparam logic [ADDR_W-1:0] A_SEC  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 2'd2;

    localparam logic [BYTE_W-1:0] SEC_RST  = 8'h80;
    localparam logic [BYTE_W-1:0] MIN_RST  = 8'h00;
    localparam logic [BYTE_W-1:0] HOUR_RST = 8'h00;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
    } tod_regs_t;
endpackage

// File: rtl/tod_bcd_wrap.sv
// Two-digit BCD step: advances by one when inc is high, wraps at MAX.
module tod_bcd_wrap #(
    parameter int          W   = 7,
    parameter logic [6:0]  MAX = 7'h59
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    localparam int TW = W - 4;

    logic [3:0]    units;
    logic [TW-1:0] tens;

    assign units = val_i[3:0];
    assign tens  = val_i[W-1:4];

    always_comb begin
        val_o   = val_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (val_i == MAX[W-1:0]) begin
                val_o   = '0;
                carry_o = 1'b1;
            end else if (units == 4'd9) begin
                val_o = {tens + 1'b1, 4'd0};
            end else begin
                val_o = {tens, units + 4'd1};
            end
        end
    end
endmodule

// File: rtl/tod_hour_step.sv
// Hour advance for both counting modes, selected by bit 7 of the byte.
module tod_hour_step (
    input  logic [7:0] hour_i,
    input  logic       inc_i,
    output logic [7:0] hour_o
);
    logic       mode12;
    logic       pm;
    logic [4:0] f12;
    logic [5:0] f24;
    logic [4:0] f12_n;
    logic [5:0] f24_n;
    logic       pm_n;

    assign mode12 = hour_i[7];
    assign pm     = hour_i[5];
    assign f12    = hour_i[4:0];
    assign f24    = hour_i[5:0];

    always_comb begin
        f12_n = f12;
        pm_n  = pm;
        if (f12 == 5'h12) begin
            f12_n = 5'h01;
        end else if (f12 == 5'h11) begin
            f12_n = 5'h12;
            pm_n  = ~pm;
        end else if (f12[3:0] == 4'd9) begin
            f12_n = {f12[4] + 1'b1, 4'd0};
        end else begin
            f12_n = {f12[4], f12[3:0] + 4'd1};
        end
    end

    always_comb begin
        if (f24 == 6'h23) begin
            f24_n = 6'h00;
        end else if (f24[3:0] == 4'd9) begin
            f24_n = {f24[5:4] + 2'd1, 4'd0};
        end else begin
            f24_n = {f24[5:4], f24[3:0] + 4'd1};
        end
    end

    always_comb begin
        if (!inc_i) begin
            hour_o = {hour_i[7], 1'b0, hour_i[5:0]};
        end else if (mode12) begin
            hour_o = {1'b1, 1'b0, pm_n, f12_n};
        end else begin
            hour_o = {1'b0, 1'b0, f24_n};
        end
    end
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    localparam int NPAIR = 2;

    tod_regs_t regs_d, regs_q;

    logic             adv;
    logic [NPAIR:0]   inc;
    logic [DIG_W-1:0] pair_in  [NPAIR];
    logic [DIG_W-1:0] pair_out [NPAIR];
    logic [7:0]       hour_nxt;

    // A tick counts only when not halted and no write is present.
    assign adv        = tick_i & ~wr_en_i & ~regs_q.sec[7];
    assign inc[0]     = adv;
    assign pair_in[0] = regs_q.sec[DIG_W-1:0];
    assign pair_in[1] = regs_q.min[DIG_W-1:0];

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        tod_bcd_wrap #(.W(DIG_W), .MAX(7'h59)) u_wrap (
            .val_i  (pair_in[g]),
            .inc_i  (inc[g]),
            .val_o  (pair_out[g]),
            .carry_o(inc[g+1])
        );
    end

    tod_hour_step u_hour (
        .hour_i(regs_q.hour),
        .inc_i (inc[NPAIR]),
        .hour_o(hour_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_SEC:   regs_d.sec  = wr_data_i;
                A_MIN:   regs_d.min  = {1'b0, wr_data_i[6:0]};
                A_HOUR:  regs_d.hour = {wr_data_i[7], 1'b0, wr_data_i[5:0]};
                default: regs_d = regs_q;
            endcase
        end else begin
            regs_d.sec  = {regs_q.sec[7], pair_out[0]};
            regs_d.min  = {1'b0, pair_out[1]};
            regs_d.hour = hour_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{sec: SEC_RST, min: MIN_RST, hour: HOUR_RST};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_SEC:   rd_data_o = regs_q.sec;
            A_MIN:   rd_data_o = regs_q.min;
            A_HOUR:  rd_data_o = regs_q.hour;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/tod_bcd_checker.sv
module tod_bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [1:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q
);
    logic live;
    logic hcarry;

    assign live   = tick_i && !wr_en_i && !sec_q[7];
    assign hcarry = live && sec_q[6:0] == 7'h59 && min_q[6:0] == 7'h59;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q))); // R4
    AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0) |=> (sec_q == $past(wr_data_i))); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q[7] == 1'b0 && hour_q[6] == 1'b0)); // R3
    AST_TICK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd1) |=> (sec_q == $past(sec_q))); // R9
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00 && min_q != $past(min_q))); // R5
    AST_H24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcarry && !hour_q[7] && hour_q[5:0] == 6'h23) |=> (hour_q == 8'h00)); // R7
    AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hcarry && hour_q[7] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5]))); // R8
    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (hour_q[7] == $past(hour_q[7]) && sec_q[7] == $past(sec_q[7]))); // R10
endmodule

bind tod_bcd_counter tod_bcd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .sec_q    (regs_q.sec),
    .min_q    (regs_q.min),
    .hour_q   (regs_q.hour)
);

// File: tb/sim_tod_bcd_counter.sv
`timescale 1ns/1ps
module sim_tod_bcd_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [1:0] rd_addr_i = 2'd0;
    logic [7:0] rd_data_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Decimal reference state
    int  m_s, m_m, m_h;
    bit  m_halt, m_mode12, m_pm;

    always #2.5 clk = ~clk;

    tod_bcd_counter u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        logic [7:0] b;
        case (a)
            0: b = {m_halt, bcd(m_s)[6:0]};
            1: b = {1'b0, bcd(m_m)[6:0]};
            2: b = m_mode12 ? {1'b1, 1'b0, m_pm, bcd(m_h)[4:0]} : {2'b00, bcd(m_h)[5:0]};
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    task automatic model_reset();
        m_halt = 1; m_s = 0; m_m = 0; m_h = 0; m_mode12 = 0; m_pm = 0;
    endtask

    task automatic model_clock(bit t, bit w, logic [1:0] a, logic [7:0] d);
        if (w) begin
            if (a == 2'd0) begin
                m_halt = d[7]; m_s = int'(d[6:4]) * 10 + int'(d[3:0]);
            end else if (a == 2'd1) begin
                m_m = int'(d[6:4]) * 10 + int'(d[3:0]);
            end else if (a == 2'd2) begin
                m_mode12 = d[7];
                if (d[7]) begin
                    m_pm = d[5]; m_h = int'(d[4]) * 10 + int'(d[3:0]);
                end else begin
                    m_pm = 0; m_h = int'(d[5:4]) * 10 + int'(d[3:0]);
                end
            end
        end else if (t && !m_halt) begin
            m_s++;
            if (m_s == 60) begin
                m_s = 0; m_m++;
                if (m_m == 60) begin
                    m_m = 0;
                    if (m_mode12) begin
                        if (m_h == 12) m_h = 1;
                        else if (m_h == 11) begin m_h = 12; m_pm = !m_pm; end
                        else m_h++;
                    end else begin
                        m_h = (m_h == 23) ? 0 : m_h + 1;
                    end
                end
            end
        end
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 3; a++) begin
            rd_addr_i = 2'(a);
            #0.2;
            total++;
            if (rd_data_o !== exp_byte(a)) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data_o, exp_byte(a));
            end
        end
    endtask

    // Called at a negedge: drive, clock once, then compare at the next negedge.
    task automatic step(bit t, bit w, logic [1:0] a, logic [7:0] d, string tag);
        tick_i = t; wr_en_i = w; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        model_clock(t, w, a, d);
        @(negedge clk);
        tick_i = 0; wr_en_i = 0;
        check_all(tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 2'd0, 8'd0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1");
        // R2: address 3 reads zero
        rd_addr_i = 2'd3; #0.2; total++;
        if (rd_data_o !== 8'h00) begin
            bad++; $display("FAIL R2 addr=3 actual=%h expected=00", rd_data_o);
        end
        ticks(5, "R4");                          // halted after reset
        step(0, 1, 2'd0, 8'h00, "R3");           // clear halt
        ticks(65, "R5");                         // seconds wrap into minutes
        step(0, 1, 2'd0, 8'h58, "R3");
        step(0, 1, 2'd1, 8'h59, "R3");
        step(0, 1, 2'd2, 8'h23, "R3");
        ticks(3, "R7");                          // 23:59:59 to 00:00:00, R6 carry
        step(0, 1, 2'd2, 8'h91, "R8");           // 12-hour, AM 11
        step(0, 1, 2'd1, 8'h59, "R8");
        step(0, 1, 2'd0, 8'h59, "R8");
        ticks(1, "R8");                          // to PM 12
        step(0, 1, 2'd1, 8'h59, "R8");
        step(0, 1, 2'd0, 8'h59, "R8");
        ticks(1, "R10");                         // PM 12 to PM 01, flag kept
        step(0, 1, 2'd2, 8'hB1, "R8");           // PM 11
        step(0, 1, 2'd1, 8'h59, "R8");
        step(0, 1, 2'd0, 8'h59, "R8");
        ticks(1, "R8");                          // to AM 12
        step(0, 1, 2'd2, 8'h09, "R7");           // 24-hour 09
        step(0, 1, 2'd1, 8'h59, "R6");
        step(0, 1, 2'd0, 8'h59, "R6");
        ticks(1, "R6");                          // 09 to 10 via carry
        step(0, 1, 2'd0, 8'h59, "R9");
        step(1, 1, 2'd1, 8'h30, "R9");           // tick dropped, no carry
        step(1, 1, 2'd3, 8'h77, "R9");           // addr 3 write still drops the tick
        step(0, 1, 2'd3, 8'h45, "R3");           // no byte changes
        step(0, 1, 2'd1, 8'hD9, "R3");           // bit 7 masked
        step(0, 1, 2'd2, 8'h45, "R3");           // bit 6 masked
        step(0, 1, 2'd0, 8'hA5, "R4");           // halt again
        ticks(10, "R4");
        step(0, 1, 2'd0, 8'h25, "R4");
        for (int i = 0; i < 4000; i++) begin
            step((i % 3) != 1, 0, 2'd0, 8'd0, "R5");
        end
        step(0, 1, 2'd2, 8'h92, "R8");           // AM 12
        for (int i = 0; i < 4000; i++) begin
            step(1, 0, 2'd0, 8'd0, "R8");
        end
        finish_run();
    end
endmodule